// File: doc/BRIEF.md
# Four-Channel Serially Programmed Setting Register

This block holds four 6-bit setting codes and loads them from a three-wire serial port. The port has a serial clock, an active-low select and a data line. The whole block runs on one fast system clock. The three serial inputs pass through synchronizers, and their edges are detected in the system clock domain. While select is low, each rising serial-clock edge shifts one bit into an 8-bit frame register. When select returns high, the frame register is decoded: its two leading bits pick a channel, and its six trailing bits become that channel's new code.

The bit that leaves the far end of the frame register drives a pull-low enable for an open-drain daisy-chain output. A second block on the same select line therefore receives its own frame when 16 bits are clocked in. An asynchronous active-low reset loads every channel with the midscale code. An active-low power-down input asserts, for every channel, a control that opens the upper terminal and a control that ties the wiper to the lower terminal. Power-down also releases the chain output, and it leaves the stored codes untouched.

Top module: `quad_setting_ctrl`

## Requirements
- R1: A frame is sent MSB first. Its first two bits form the channel number and its last six bits form the code. Channel n is held in `chanCode[6n+5:6n]`: value 0 selects bits 5:0 and value 3 selects bits 23:18.
- R2: Serial-clock rising edges have no effect on the frame register while `selN` is high.
- R3: When `selN` rises, only the addressed channel takes the new code. The other channels keep their values, and no code changes while `selN` stays high.
- R4: When more than eight bits are clocked in one frame, only the last eight are decoded.
- R5: A frame with fewer than eight clocks commits the current frame register. This is the older bits shifted up, followed by the new bits.
- R6: When `rstN` is low, every channel reads 0x20 and the frame register and chain-output latch are cleared. With `offN` high, `soPullLow` is therefore 1 after reset.
- R7: After each shift, `soPullLow` is the inverse of the bit shifted in eight shifts earlier, as long as `offN` is high.
- R8: While `offN` is low, all bits of `termOpen` and `wiperToB` are 1 and `soPullLow` is 0. While `offN` is high, `termOpen` and `wiperToB` are all 0.
- R9: Stored codes survive power-down unchanged. Frames sent during power-down still load, and they appear on `chanCode`.
- R10: A reset that starts together with a commit wins: every channel ends at 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Asynchronous active-low reset to midscale |
| sclkIn | input | 1 | Serial clock |
| selN | input | 1 | Active-low frame select |
| sdataIn | input | 1 | Serial data in |
| offN | input | 1 | Active-low power-down |
| chanCode | output | 24 | Four 6-bit channel codes, channel 0 in the low bits |
| termOpen | output | 4 | Per channel: open the upper terminal |
| wiperToB | output | 4 | Per channel: tie the wiper to the lower terminal |
| soPullLow | output | 1 | Open-drain chain output; 1 pulls the line low |

## Verification
The bench sweeps every channel address against every code value. After each commit it compares all four channels, so a decoder that wrote the wrong channel, or more than one, is caught at once. It clocks serial edges with select high and then commits an empty frame. A design that shifted while deselected would load channel 3 with 0x3F. Long and short frames separate a design that decodes the first eight bits, or clears the register per frame, from one that decodes the last eight bits it received. A 16-bit frame checks the chain output after every shift, which catches a delay that is off by one. Power-down tests confirm that the codes are kept, that loading goes on during power-down, and that the output is released. A reset that coincides with a commit must not let the commit through.

// File: rtl/setting_pkg.sv
package setting_pkg;
  // Strobes from the serial front end to the datapath, one system cycle wide.
  typedef struct packed {
    logic shift;   // one serial bit accepted
    logic commit;  // frame select released: decode the frame
  } strobe_t;
endpackage

// File: rtl/setting_serial_ctrl.sv
module setting_serial_ctrl
  import setting_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkIn,
  input  logic    selN,
  input  logic    sdataIn,
  output strobe_t strobe,
  output logic    bitIn
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclkSync, selSync, dataSync;
  logic          sclkPrev, selPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      selSync  <= '1;
      dataSync <= '0;
      sclkPrev <= 1'b0;
      selPrev  <= 1'b1;
    end else begin
      sclkSync <= {sclkSync[LAST-1:0], sclkIn};
      selSync  <= {selSync[LAST-1:0], selN};
      dataSync <= {dataSync[LAST-1:0], sdataIn};
      sclkPrev <= sclkSync[LAST];
      selPrev  <= selSync[LAST];
    end
  end

  // A serial rising edge counts only while the frame is selected.
  always_comb begin
    strobe.shift  = sclkSync[LAST] & ~sclkPrev & ~selSync[LAST];
    strobe.commit = selSync[LAST] & ~selPrev;
    bitIn         = dataSync[LAST];
  end
endmodule

// File: rtl/setting_datapath.sv
module setting_datapath
  import setting_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int CODE_W   = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strobe,
  input  logic                       bitIn,
  output logic [CHANNELS*CODE_W-1:0] codes,
  output logic                       outBit
);
  localparam int ADDR_W  = $clog2(CHANNELS);
  localparam int FRAME_W = ADDR_W + CODE_W;
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  logic [FRAME_W-1:0] frameQ;
  logic [ADDR_W-1:0]  frameAddr;

  assign frameAddr = frameQ[FRAME_W-1 -: ADDR_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ <= '0;
      outBit <= 1'b0;
    end else if (strobe.shift) begin
      outBit <= frameQ[FRAME_W-1];
      frameQ <= {frameQ[FRAME_W-2:0], bitIn};
    end
  end

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic [CODE_W-1:0] codeQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        codeQ <= MID;
      else if (strobe.commit && frameAddr == ADDR_W'(ch))
        codeQ <= frameQ[CODE_W-1:0];
    end
    assign codes[ch*CODE_W +: CODE_W] = codeQ;
  end
endmodule

// File: rtl/quad_setting_ctrl.sv
module quad_setting_ctrl
  import setting_pkg::*;
#(
  parameter int CHANNELS    = 4,
  parameter int CODE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclkIn,
  input  logic                       selN,
  input  logic                       sdataIn,
  input  logic                       offN,
  output logic [CHANNELS*CODE_W-1:0] chanCode,
  output logic [CHANNELS-1:0]        termOpen,
  output logic [CHANNELS-1:0]        wiperToB,
  output logic                       soPullLow
);
  strobe_t strobe;
  logic    bitIn;
  logic    outBit;

  setting_serial_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .selN(selN),
    .sdataIn(sdataIn), .strobe(strobe), .bitIn(bitIn)
  );

  setting_datapath #(.CHANNELS(CHANNELS), .CODE_W(CODE_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitIn(bitIn),
    .codes(chanCode), .outBit(outBit)
  );

  // Power-down only steers the terminal switches; stored codes are untouched.
  assign termOpen  = {CHANNELS{~offN}};
  assign wiperToB  = {CHANNELS{~offN}};
  assign soPullLow = offN & ~outBit;
endmodule

// File: rtl/quad_setting_chk.sv
module quad_setting_chk #(
  parameter int CHANNELS = 4,
  parameter int CODE_W   = 6
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       selN,
  input logic                       offN,
  input logic [CHANNELS*CODE_W-1:0] chanCode,
  input logic [CHANNELS-1:0]        termOpen,
  input logic [CHANNELS-1:0]        wiperToB,
  input logic                       soPullLow
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  logic [CHANNELS*CODE_W-1:0] prevCode;
  logic [CHANNELS-1:0]        chgMask;
  logic [2:0]                 hiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCode <= {CHANNELS{MID}};
      hiCnt    <= '0;
    end else begin
      prevCode <= chanCode;
      if (!selN)            hiCnt <= '0;
      else if (hiCnt != 3'd7) hiCnt <= hiCnt + 3'd1;
    end
  end

  always_comb
    for (int i = 0; i < CHANNELS; i++)
      chgMask[i] = chanCode[i*CODE_W +: CODE_W] != prevCode[i*CODE_W +: CODE_W];

  always @(posedge clk)
    if (!rstN)
      p_reset_mid_r6: assert (chanCode == {CHANNELS{MID}});

  p_one_channel_r3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(chgMask) <= 1);

  p_hold_deselected_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hiCnt >= 3'd4) |-> $stable(chanCode));

  p_sdo_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    !offN |-> !soPullLow);

  p_shdn_terms_r8: assert property (@(posedge clk) disable iff (!rstN)
    !offN |-> (&termOpen && &wiperToB));
endmodule

bind quad_setting_ctrl quad_setting_chk #(.CHANNELS(CHANNELS), .CODE_W(CODE_W)) chk (
  .clk(clk), .rstN(rstN), .selN(selN), .offN(offN), .chanCode(chanCode),
  .termOpen(termOpen), .wiperToB(wiperToB), .soPullLow(soPullLow)
);

// File: tb/quad_setting_ctrl_test.sv
`timescale 1ns/1ps
module quad_setting_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b1, sclkIn = 1'b0, selN = 1'b1, sdataIn = 1'b0, offN = 1'b1;
  logic [23:0] chanCode;
  logic [3:0]  termOpen, wiperToB;
  logic        soPullLow;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [5:0] codeM [4];
  logic [7:0] srM;
  logic       sdoM;

  always #2.5 clk = ~clk;

  quad_setting_ctrl uut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .selN(selN), .sdataIn(sdataIn),
    .offN(offN), .chanCode(chanCode), .termOpen(termOpen), .wiperToB(wiperToB),
    .soPullLow(soPullLow)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 4; i++) codeM[i] = 6'h20;
    srM = 8'h00;
    sdoM = 1'b0;
  endtask

  task automatic shiftBit(bit b);
    sdataIn = b;
    tick(4);
    sclkIn = 1'b1;
    tick(4);
    sclkIn = 1'b0;
    if (!selN) begin
      sdoM = srM[7];
      srM  = {srM[6:0], b};
    end
  endtask

  task automatic sendBits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) shiftBit(v[i]);
  endtask

  task automatic endFrame();
    selN = 1'b1;
    tick(6);
    codeM[srM[7:6]] = srM[5:0];
  endtask

  task automatic frame(logic [31:0] v, int n);
    selN = 1'b0;
    tick(4);
    sendBits(v, n);
    endFrame();
  endtask

  task automatic checkCodes(string req);
    for (int i = 0; i < 4; i++)
      check(chanCode[i*6 +: 6] == codeM[i], req, chanCode[i*6 +: 6], codeM[i]);
  endtask

  task automatic checkSdo(string req);
    check(soPullLow == (offN & ~sdoM), req, soPullLow, offN & ~sdoM);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    modelReset();
    #1 rstN = 1'b0;
    tick(4);
    // R6: reset state of codes and chain output
    checkCodes("R6 reset");
    checkSdo("R6 reset sdo");
    check(termOpen == 4'h0 && wiperToB == 4'h0, "R8 on", {termOpen, wiperToB}, 0);
    rstN = 1'b1;
    tick(4);

    // R1/R3: exhaustive sweep of address and code
    for (int a = 0; a < 4; a++)
      for (int d = 0; d < 64; d++) begin
        frame({a[1:0], d[5:0]}, 8);
        checkCodes("R1 R3 sweep");
      end

    // R2: clocks with select high must not shift
    frame({2'd3, 6'h11}, 8);
    frame({2'd0, 6'h05}, 8);
    sendBits(32'hFF, 8);
    tick(4);
    checkCodes("R2 idle");
    selN = 1'b0; tick(4); endFrame();
    checkCodes("R2 empty commit");
    checkSdo("R2 sdo");

    // R4: long frame uses last eight bits
    frame({4'hF, 2'd2, 6'h2A}, 12);
    checkCodes("R4 long");
    frame({6'h3F, 2'd1, 6'h13}, 14);
    checkCodes("R4 long2");

    // R5: short frame commits shifted register
    frame({2'd2, 6'h0C}, 8);
    frame(32'h5, 3);
    checkCodes("R5 short3");
    frame(32'h0, 1);
    checkCodes("R5 short1");

    // R7: 16-bit frame, chain output after every shift
    selN = 1'b0; tick(4);
    for (int i = 15; i >= 0; i--) begin
      logic [15:0] pat = 16'b1011_0010_0110_1101;
      shiftBit(pat[i]);
      checkSdo("R7 chain");
    end
    endFrame();
    checkCodes("R7 commit");

    // R8/R9: power-down keeps codes, still loads
    offN = 1'b0; tick(2);
    check(termOpen == 4'hF && wiperToB == 4'hF, "R8 off", {termOpen, wiperToB}, 8'hFF);
    check(soPullLow == 1'b0, "R8 release", soPullLow, 0);
    checkCodes("R9 kept");
    frame({2'd3, 6'h01}, 8);
    checkCodes("R9 load in off");
    check(soPullLow == 1'b0, "R8 release2", soPullLow, 0);
    offN = 1'b1; tick(2);
    check(termOpen == 4'h0 && wiperToB == 4'h0, "R8 back", {termOpen, wiperToB}, 0);
    checkCodes("R9 restore");
    checkSdo("R7 after off");

    // R10: reset together with commit
    selN = 1'b0; tick(4);
    sendBits({2'd1, 6'h3E}, 8);
    selN = 1'b1; rstN = 1'b0;
    tick(8);
    rstN = 1'b1;
    modelReset();
    tick(6);
    checkCodes("R10 reset wins");
    checkSdo("R6 sdo cleared");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule